// File: doc/BRIEF.md
# Drift-Tolerant Bit Timing Recovery

This block takes a serial line at a nominal bit rate and recovers its bit timing. The line comes from a transmitter whose clock has no fixed phase relation to the local one. The block runs on a fast clock at `OSR` samples per bit period. It divides that clock into a half-bit slot strobe, which acts as a clock enable at twice the bit rate. A bit enable rides on alternate slot strobes, so logic downstream that is qualified by both strobes advances once per bit.

Each line transition, once synchronized, is timed against a local phase counter. The expected bit boundary is phase 0, and the sample point is mid-bit at phase `OSR/2`. A transition that lands more than `GUARD` samples from the boundary schedules one correction:
- If transitions arrive late, the bit enable skips one extra slot, which lengthens the local bit by half a bit.
- If transitions arrive early, the enable is given on two slots in a row, which shortens the local bit by half a bit.

A long run of equal bits has no transitions, so the enable keeps its plain alternating pattern. The block sits at the front of a receive path, ahead of any word matching. The recovered stream cannot be paused: a consumer must take every bit on the cycle that `bit_en_o` is high, so the outputs carry no back-pressure.

Top module: `bitclk_recover`

## Requirements
- R1: While `rst_n` is low, `slot_tick_o`, `bit_en_o` and `bit_o` are all 0.
- R2: With no correction pending, `slot_tick_o` pulses for one cycle every `OSR/2` cycles. `bit_en_o` is high only in a cycle where `slot_tick_o` is high, and it is high on alternate slot ticks.
- R3: The line passes through a `SYNC_STAGES`-flop synchronizer. Each synchronized transition is given a signed phase error in the range -`OSR/2` to `OSR/2`-1. A local phase of `OSR/2` or above counts as early: it maps to phase minus `OSR`.
- R4: A transition whose phase error lies within ±`GUARD` schedules no correction. With the defaults (16, 4), a line at exactly the nominal rate gives a gap of exactly two slot ticks between bit enables once it has locked.
- R5: A phase error above +`GUARD` (a late transition) withholds the bit enable at one extra slot tick. This gives three slot ticks from one bit enable to the next.
- R6: A phase error below -`GUARD` (an early transition) gives the bit enable on two consecutive slot ticks.
- R7: Two corrections are always at least `OSR` cycles apart. Two successive enable gaps are never both corrected.
- R8: When the line has no transitions, the bit enable keeps the plain alternating pattern with no correction.
- R9: `bit_o` takes the synchronized line level at the mid-bit slot and changes only in a cycle where `bit_en_o` is high. It holds its value in every other cycle.
- R10: For a line rate within ±1/64 of nominal, the stream seen on `bit_o` at `bit_en_o` matches the sent bits one for one after lock, with no dropped or repeated bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, `OSR` cycles per nominal bit |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_i | input | 1 | Asynchronous serial line |
| slot_tick_o | output | 1 | Half-bit slot strobe (twice-bit-rate enable) |
| bit_en_o | output | 1 | Bit enable, high only together with `slot_tick_o` |
| bit_o | output | 1 | Recovered data bit, valid while `bit_en_o` is high |

## Verification
The embedded assertions guard the following on every cycle:
- the bit enable appears only on a slot tick;
- slot ticks never fall on adjacent cycles;
- `bit_o` holds its value between enables;
- a scheduled correction can only arise from a measured transition and cannot switch direction;
- corrections stay at least `OSR` cycles apart.

Other behaviour shows only in the bench's line scenarios:
- the three-tick and one-tick enable gaps that fast and slow lines must produce;
- the absence of any correction on a nominal-rate line and on an idle line;
- bit-exact recovery of a payload through drift.

// File: rtl/bitclk_pkg.sv
`timescale 1ns/1ps
package bitclk_pkg;

  // Pending phase correction for the next eligible slot
  typedef enum logic [1:0] {
    CORR_NONE = 2'd0,
    CORR_ADV  = 2'd1,   // enable on two consecutive slots
    CORR_DLY  = 2'd2    // skip the enable on one extra slot
  } corr_e;

endpackage

// File: rtl/bitclk_edge_sync.sv
`timescale 1ns/1ps
module bitclk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic data_o,
  output logic edge_o
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= rx_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  assign data_o = sync_q[STAGES-1];
  assign edge_o = sync_q[STAGES-1] ^ last_q;

endmodule

// File: rtl/bitclk_phase_track.sv
`timescale 1ns/1ps
module bitclk_phase_track
  import bitclk_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  corr_e           pend_i,
  output logic [$clog2(OSR)-1:0] ph_o,
  output logic            slot_o,
  output logic            en_o,
  output logic            applied_o
);

  localparam int PW = $clog2(OSR);
  localparam int HALF = OSR / 2;
  localparam logic [PW-1:0] PH_ZERO  = '0;
  localparam logic [PW-1:0] PH_ONE   = PW'(1);
  localparam logic [PW-1:0] PH_HALF  = PW'(HALF);
  localparam logic [PW-1:0] PH_HALF1 = PW'(HALF + 1);

  logic [PW-1:0] ph_q;
  logic          at_zero, at_half, adv_now, dly_now;

  always_comb begin
    at_zero   = (ph_q == PH_ZERO);
    at_half   = (ph_q == PH_HALF);
    adv_now   = at_zero && (pend_i == CORR_ADV);
    dly_now   = at_half && (pend_i == CORR_DLY);
    slot_o    = at_zero || at_half;
    en_o      = (at_half && !dly_now) || adv_now;
    applied_o = adv_now || dly_now;
  end

  // Advance jumps the phase forward half a bit; delay pulls it back.
  always_ff @(posedge clk) begin
    if (!rst_n)       ph_q <= PH_ZERO;
    else if (adv_now) ph_q <= PH_HALF1;
    else if (dly_now) ph_q <= PH_ONE;
    else              ph_q <= ph_q + PH_ONE;
  end

  assign ph_o = ph_q;

  // Checker: cycles since the last applied correction, saturating
  logic [PW:0] since_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                      since_q <= (PW+1)'(OSR);
    else if (applied_o)              since_q <= (PW+1)'(1);
    else if (since_q < (PW+1)'(OSR)) since_q <= since_q + (PW+1)'(1);
  end

  p_one_corr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    applied_o |-> (since_q >= (PW+1)'(OSR)))
    else $error("corrections closer than OSR cycles");

  p_slot_sep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    slot_o |=> !slot_o)
    else $error("slot strobes on adjacent cycles");

endmodule

// File: rtl/bitclk_drift_judge.sv
`timescale 1ns/1ps
module bitclk_drift_judge
  import bitclk_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int GUARD = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   edge_i,
  input  logic [$clog2(OSR)-1:0] ph_i,
  input  logic                   applied_i,
  output corr_e                  pend_o
);

  localparam int PW = $clog2(OSR);
  localparam int HALF = OSR / 2;

  int          err;
  corr_e       pend_q;
  logic [PW:0] cool_q;

  // Signed distance of the transition from the expected boundary
  always_comb begin
    err = int'(ph_i);
    if (int'(ph_i) >= HALF) err = err - OSR;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= CORR_NONE;
    end else if (applied_i) begin
      pend_q <= CORR_NONE;
    end else if (pend_q == CORR_NONE && cool_q == '0 && edge_i) begin
      if (err > GUARD)       pend_q <= CORR_DLY;
      else if (err < -GUARD) pend_q <= CORR_ADV;
    end
  end

  // Hold-off after a correction so the shifted phase settles
  always_ff @(posedge clk) begin
    if (!rst_n)           cool_q <= '0;
    else if (applied_i)   cool_q <= (PW+1)'(OSR);
    else if (cool_q != 0) cool_q <= cool_q - (PW+1)'(1);
  end

  assign pend_o = pend_q;

  p_pend_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != CORR_NONE && $past(pend_q) == CORR_NONE) |-> $past(edge_i))
    else $error("correction scheduled without a transition");

  p_no_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q != CORR_NONE) |=> (pend_q == $past(pend_q) || pend_q == CORR_NONE))
    else $error("pending correction changed direction");

endmodule

// File: rtl/bitclk_sampler.sv
`timescale 1ns/1ps
module bitclk_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_i,
  input  logic en_i,
  input  logic data_i,
  output logic slot_tick_o,
  output logic bit_en_o,
  output logic bit_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_tick_o <= 1'b0;
      bit_en_o    <= 1'b0;
      bit_o       <= 1'b0;
    end else begin
      slot_tick_o <= slot_i;
      bit_en_o    <= en_i;
      if (en_i) bit_o <= data_i;
    end
  end

  p_en_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en_o |-> slot_tick_o)
    else $error("bit enable outside a slot tick");

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en_o |-> $stable(bit_o))
    else $error("data bit changed without enable");

endmodule

// File: rtl/bitclk_recover.sv
`timescale 1ns/1ps
module bitclk_recover
  import bitclk_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int GUARD       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic slot_tick_o,
  output logic bit_en_o,
  output logic bit_o
);

  localparam int PW = $clog2(OSR);

  logic          data_s, edge_s, slot_s, en_s, applied_s;
  logic [PW-1:0] ph_s;
  corr_e         pend_s;

  bitclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_i   (rx_i),
    .data_o (data_s),
    .edge_o (edge_s)
  );

  bitclk_phase_track #(.OSR(OSR)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_i    (pend_s),
    .ph_o      (ph_s),
    .slot_o    (slot_s),
    .en_o      (en_s),
    .applied_o (applied_s)
  );

  bitclk_drift_judge #(.OSR(OSR), .GUARD(GUARD)) u_judge (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_i    (edge_s),
    .ph_i      (ph_s),
    .applied_i (applied_s),
    .pend_o    (pend_s)
  );

  bitclk_sampler u_samp (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_i      (slot_s),
    .en_i        (en_s),
    .data_i      (data_s),
    .slot_tick_o (slot_tick_o),
    .bit_en_o    (bit_en_o),
    .bit_o       (bit_o)
  );

endmodule

// File: tb/bitclk_recover_tb_top.sv
`timescale 1ns/1ps
module bitclk_recover_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b0;
  logic slot_tick_o, bit_en_o, bit_o;

  int checks = 0;
  int errors = 0;

  bitclk_recover dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_i        (rx),
    .slot_tick_o (slot_tick_o),
    .bit_en_o    (bit_en_o),
    .bit_o       (bit_o)
  );

  always #2 clk = ~clk;   // 250 MHz

  localparam logic [7:0] MARK = 8'b1111_0010;

  bit   exp_q[$];
  int   cyc = 0, last_tick = -1, ticks_since = 0;
  bit   idle_chk = 0, have_en = 0, armed = 0, locked = 0;
  int   left = 0, n_dbl = 0, n_ext = 0, n_b2b = 0, n_bad = 0, prev_gap = 2;
  logic [7:0] shreg = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      int gap;
      cyc++;
      if (slot_tick_o) begin
        if (idle_chk && last_tick >= 0)
          chk(cyc - last_tick == 8, "R2 slot tick spacing", cyc - last_tick, 8);
        last_tick = cyc;
        ticks_since++;
      end
      if (bit_en_o) begin
        chk(slot_tick_o == 1'b1, "R2 enable on slot tick", int'(slot_tick_o), 1);
        gap = ticks_since;
        ticks_since = 0;
        if (idle_chk && have_en) chk(gap == 2, "R8 idle enable gap", gap, 2);
        have_en = 1;
        shreg = {shreg[6:0], bit_o};
        if (locked) begin
          bit e;
          if (gap == 1) n_dbl++;
          else if (gap == 3) n_ext++;
          else if (gap != 2) n_bad++;
          if (gap != 2 && prev_gap != 2) n_b2b++;
          prev_gap = gap;
          if (exp_q.size() == 0) begin
            chk(0, "R10 unexpected bit", 1, 0);
          end else begin
            e = exp_q.pop_front();
            chk(bit_o == e, "R9 R3 recovered bit", int'(bit_o), int'(e));
          end
          left--;
          if (left == 0) begin locked = 0; armed = 0; end
        end else if (armed && shreg == MARK) begin
          locked = 1;
          prev_gap = 2;
        end
      end
    end
  end

  task automatic send_bit(input bit b, input real per);
    rx = b;
    #(per);
  endtask

  task automatic send_stream(input real per, input int nbits);
    logic [6:0] lfsr = 7'h5A;
    exp_q.delete();
    n_dbl = 0; n_ext = 0; n_b2b = 0; n_bad = 0;
    left = nbits;
    locked = 0;
    armed = 1;
    @(negedge clk); #1;
    for (int i = 0; i < 24; i++) send_bit(i % 2 == 0, per);
    for (int i = 7; i >= 0; i--) send_bit(MARK[i], per);
    for (int i = 0; i < nbits; i++) begin
      bit b;
      b = lfsr[6];
      lfsr = {lfsr[5:0], lfsr[6] ^ lfsr[5]};
      exp_q.push_back(b);
      send_bit(b, per);
    end
    for (int i = 0; i < 8; i++) send_bit(rx, per);
    chk(left == 0, "R10 all payload bits recovered", left, 0);
    chk(n_b2b == 0, "R7 adjacent corrections", n_b2b, 0);
    chk(n_bad == 0, "R7 enable gap out of range", n_bad, 0);
  endtask

  task automatic run_all();
    // Reset state
    repeat (4) begin
      @(negedge clk);
      chk(slot_tick_o == 0 && bit_en_o == 0 && bit_o == 0, "R1 reset outputs",
          int'({slot_tick_o, bit_en_o, bit_o}), 0);
    end
    rst_n = 1'b1;
    // Idle line: plain pattern
    idle_chk = 1;
    repeat (200) @(negedge clk);
    idle_chk = 0;
    // Nominal rate: no correction once locked
    send_stream(64.0, 96);
    chk(n_dbl == 0 && n_ext == 0, "R4 nominal rate no correction", n_dbl + n_ext, 0);
    // Slow line: late edges
    send_stream(65.0, 96);
    chk(n_ext >= 1, "R5 extra low slot seen", n_ext, 1);
    chk(n_dbl == 0, "R5 no double enable on slow line", n_dbl, 0);
    // Fast line: early edges
    send_stream(63.0, 96);
    chk(n_dbl >= 1, "R6 double enable seen", n_dbl, 1);
    chk(n_ext == 0, "R6 no extra low slot on fast line", n_ext, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule